// File: doc/BRIEF.md
# Strided Cube Copy Address Generator

This block turns one copy descriptor into the full sequence of source and destination addresses needed to move a three-dimensional data cube in 32-byte beats. A cube is a stack of surfaces, a surface is a stack of lines, and a line is a run of consecutive 32-byte beats. Each side of the copy has its own line pitch and surface pitch. Because of this, padding after each line and after each surface is skipped independently on the source and on the destination, and a packed layout can be copied into a padded one or the other way round.

The descriptor is presented together with a one-cycle `start` pulse while the block is idle. The line length and the line count are given minus one, in beats and in lines. The surface count is given as a plain number. After an accepted start, the block offers one source/destination address pair per beat on a valid/ready handshake. It marks the final pair and pulses `done` in the same cycle the final pair is taken. A descriptor whose bases or pitches are not multiples of 32 bytes, or whose surface count is zero, is rejected with a one-cycle error pulse and issues no beats. Moving the data and any bus protocol belong to the surrounding logic.

Top module: `cube_addr_gen`

## Requirements
- R1: After reset, `beat_valid`, `beat_last`, `done`, `cfg_err` and `busy` are all 0.
- R2: Within a line, each accepted beat is followed by an address pair 32 bytes higher on both sides, and every offered address has bits [4:0] equal to 0.
- R3: After the last beat of a line that is not the last line of its surface, the next address on each side is that line's starting address plus that side's line pitch.
- R4: After the last beat of the last line of a surface, the next address on each side is that surface's starting address plus that side's surface pitch.
- R5: A descriptor yields exactly (line_beats_m1+1) x (lines_m1+1) x surfaces beats. `beat_last` is 1 only on the final beat, `done` is 1 only in the cycle that beat is accepted, and the cycle after `done` has `beat_valid` at 0.
- R6: If any base or pitch has a nonzero value in bits [4:0], or `surfaces` is 0, then the cycle after `start` has `cfg_err` at 1 with `beat_valid` and `busy` at 0. `cfg_err` returns to 0 the cycle after that.
- R7: While `beat_valid` is 1 and `beat_ready` is 0, the offered addresses and `beat_valid` hold unchanged. The sequence advances only on a handshake.
- R8: `start` and all descriptor inputs are ignored while `busy` is 1. The address sequence in flight is unaffected.
- R9: In the cycle after an accepted valid `start`, `beat_valid` and `busy` are 1 and the addresses equal the two base addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Descriptor strobe, taken only when idle |
| src_base | input | ADDR_W | Source cube start byte address |
| dst_base | input | ADDR_W | Destination cube start byte address |
| line_beats_m1 | input | LEN_W | Beats per line minus one |
| lines_m1 | input | REP_W | Lines per surface minus one |
| surfaces | input | SURF_W | Surfaces per cube |
| src_line_pitch | input | ADDR_W | Source bytes from line to line |
| dst_line_pitch | input | ADDR_W | Destination bytes from line to line |
| src_surf_pitch | input | ADDR_W | Source bytes from surface to surface |
| dst_surf_pitch | input | ADDR_W | Destination bytes from surface to surface |
| beat_ready | input | 1 | Consumer accepts the offered pair |
| beat_valid | output | 1 | An address pair is offered |
| beat_src_addr | output | ADDR_W | Source address of the offered beat |
| beat_dst_addr | output | ADDR_W | Destination address of the offered beat |
| beat_last | output | 1 | Offered beat is the final one |
| done | output | 1 | Final beat accepted this cycle |
| busy | output | 1 | A descriptor is being walked |
| cfg_err | output | 1 | Rejected descriptor, one-cycle pulse |

## Verification
The first address pair and `busy` are due one clock edge after the `start` is sampled. Each later pair is due one edge after a handshake. `done` and `beat_last` are combinational with the accepted final beat, and `cfg_err` appears one edge after a rejected start and lasts one cycle. The bench drives inputs on the falling edge and samples one time unit later. The beat index advances only when the bench itself saw `beat_ready` high with `beat_valid` at that sample, so each expected address comes from the bench's own count of handshakes. Random ready stalls and random `start` pulses during a run test the hold and ignore rules in the same cycles where they could go wrong.

// File: rtl/cag_pkg.sv
package cag_pkg;
  localparam int BEAT_BYTES = 32;
  localparam int BEAT_LG    = 5;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} cag_state_e;

  // Low-bit test for 32-byte alignment on a 32-bit value.
  function automatic logic low_clear(input logic [BEAT_LG-1:0] low);
    return low == '0;
  endfunction
endpackage

// File: rtl/cag_level_ctr.sv
module cag_level_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         at_end
);
  logic [W-1:0] count;

  assign at_end = (count == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (clear)  count <= '0;
    else if (step)   count <= at_end ? '0 : count + W'(1);
  end
endmodule

// File: rtl/cag_side_track.sv
module cag_side_track #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] line_pitch,
  input  logic [ADDR_W-1:0] surf_pitch,
  input  logic              advance,
  input  logic              line_done,
  input  logic              surf_done,
  output logic [ADDR_W-1:0] addr
);
  import cag_pkg::*;

  logic [ADDR_W-1:0] cur_q, line_q, surf_q;
  logic [ADDR_W-1:0] cur_d, line_d, surf_d;

  always_comb begin
    cur_d  = cur_q;
    line_d = line_q;
    surf_d = surf_q;
    if (load) begin
      cur_d  = base;
      line_d = base;
      surf_d = base;
    end else if (advance) begin
      if (!line_done) begin
        cur_d = cur_q + ADDR_W'(BEAT_BYTES);
      end else if (!surf_done) begin
        line_d = line_q + line_pitch;
        cur_d  = line_d;
      end else begin
        surf_d = surf_q + surf_pitch;
        line_d = surf_d;
        cur_d  = surf_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q  <= '0;
      line_q <= '0;
      surf_q <= '0;
    end else begin
      cur_q  <= cur_d;
      line_q <= line_d;
      surf_q <= surf_d;
    end
  end

  assign addr = cur_q;
endmodule

// File: rtl/cag_desc_check.sv
module cag_desc_check #(
  parameter int ADDR_W = 32,
  parameter int SURF_W = 8
) (
  input  logic [5:0][ADDR_W-1:0] words,
  input  logic [SURF_W-1:0]      surfaces,
  output logic                   desc_ok
);
  import cag_pkg::*;

  logic [5:0] word_ok;

  for (genvar i = 0; i < 6; i++) begin : g_word
    assign word_ok[i] = low_clear(words[i][BEAT_LG-1:0]);
  end

  assign desc_ok = (&word_ok) && (surfaces != '0);
endmodule

// File: rtl/cube_addr_gen.sv
module cube_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int REP_W  = 8,
  parameter int SURF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [LEN_W-1:0]  line_beats_m1,
  input  logic [REP_W-1:0]  lines_m1,
  input  logic [SURF_W-1:0] surfaces,
  input  logic [ADDR_W-1:0] src_line_pitch,
  input  logic [ADDR_W-1:0] dst_line_pitch,
  input  logic [ADDR_W-1:0] src_surf_pitch,
  input  logic [ADDR_W-1:0] dst_surf_pitch,
  input  logic              beat_ready,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_src_addr,
  output logic [ADDR_W-1:0] beat_dst_addr,
  output logic              beat_last,
  output logic              done,
  output logic              busy,
  output logic              cfg_err
);
  import cag_pkg::*;

  localparam int SIDES = 2;

  cag_state_e state_q;
  logic       err_q;
  logic       desc_ok, accept, launch, fire;
  logic       beat_end, line_end, surf_end;
  logic       step_in_line;

  logic [LEN_W-1:0]  len_q;
  logic [REP_W-1:0]  rep_q;
  logic [SURF_W-1:0] surf_lim_q;
  logic [SIDES-1:0][ADDR_W-1:0] lp_q, sp_q;
  logic [SIDES-1:0][ADDR_W-1:0] base_in, lp_in, sp_in, addr_out;

  assign base_in = {dst_base, src_base};
  assign lp_in   = {dst_line_pitch, src_line_pitch};
  assign sp_in   = {dst_surf_pitch, src_surf_pitch};

  cag_desc_check #(.ADDR_W(ADDR_W), .SURF_W(SURF_W)) u_check (
    .words    ({dst_surf_pitch, src_surf_pitch, dst_line_pitch,
                src_line_pitch, dst_base, src_base}),
    .surfaces (surfaces),
    .desc_ok  (desc_ok)
  );

  assign accept       = start && (state_q == ST_IDLE);
  assign launch       = accept && desc_ok;
  assign beat_valid   = (state_q == ST_RUN);
  assign fire         = beat_valid && beat_ready;
  assign step_in_line = fire && !beat_end;
  assign beat_last    = beat_valid && beat_end && line_end && surf_end;
  assign done         = fire && beat_last;
  assign busy         = beat_valid;
  assign cfg_err      = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      err_q      <= 1'b0;
      len_q      <= '0;
      rep_q      <= '0;
      surf_lim_q <= '0;
      lp_q       <= '0;
      sp_q       <= '0;
    end else begin
      err_q <= accept && !desc_ok;
      if (launch) begin
        state_q    <= ST_RUN;
        len_q      <= line_beats_m1;
        rep_q      <= lines_m1;
        surf_lim_q <= surfaces - SURF_W'(1);
        lp_q       <= lp_in;
        sp_q       <= sp_in;
      end else if (done) begin
        state_q <= ST_IDLE;
      end
    end
  end

  cag_level_ctr #(.W(LEN_W)) u_beat_ctr (
    .clk (clk), .rst_n (rst_n), .clear (launch),
    .step (fire), .limit (len_q), .at_end (beat_end)
  );

  cag_level_ctr #(.W(REP_W)) u_line_ctr (
    .clk (clk), .rst_n (rst_n), .clear (launch),
    .step (fire && beat_end), .limit (rep_q), .at_end (line_end)
  );

  cag_level_ctr #(.W(SURF_W)) u_surf_ctr (
    .clk (clk), .rst_n (rst_n), .clear (launch),
    .step (fire && beat_end && line_end), .limit (surf_lim_q), .at_end (surf_end)
  );

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    cag_side_track #(.ADDR_W(ADDR_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (launch),
      .base       (base_in[s]),
      .line_pitch (lp_q[s]),
      .surf_pitch (sp_q[s]),
      .advance    (fire),
      .line_done  (beat_end),
      .surf_done  (line_end),
      .addr       (addr_out[s])
    );
  end

  assign beat_src_addr = addr_out[0];
  assign beat_dst_addr = addr_out[1];
endmodule

// File: rtl/cag_checker.sv
module cag_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_src_addr,
  input logic [ADDR_W-1:0] beat_dst_addr,
  input logic              done,
  input logic              busy,
  input logic              cfg_err,
  input logic              step_in_line
);
  // R2: a beat inside a line moves both sides by one beat
  a_r2_step_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    step_in_line |=> (beat_src_addr == $past(beat_src_addr) + ADDR_W'(32)) &&
                     (beat_dst_addr == $past(beat_dst_addr) + ADDR_W'(32)));

  // R2: offered addresses stay on 32-byte boundaries
  a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> (beat_src_addr[4:0] == 5'd0) && (beat_dst_addr[4:0] == 5'd0));

  // R7: a stalled beat holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid && !beat_ready) |=> beat_valid && $stable(beat_src_addr) &&
                                    $stable(beat_dst_addr));

  // R5: nothing is offered after completion
  a_r5_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !beat_valid);

  // R6: a rejected descriptor issues nothing
  a_r6_err_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !beat_valid && !busy);

  // R6: the error flag is a single-cycle pulse
  a_r6_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !cfg_err);
endmodule

bind cube_addr_gen cag_checker #(.ADDR_W(ADDR_W)) u_cag_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .beat_valid    (beat_valid),
  .beat_ready    (beat_ready),
  .beat_src_addr (beat_src_addr),
  .beat_dst_addr (beat_dst_addr),
  .done          (done),
  .busy          (busy),
  .cfg_err       (cfg_err),
  .step_in_line  (step_in_line)
);

// File: tb/cube_addr_gen_bench.sv
module cube_addr_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] src_base = '0, dst_base = '0;
  logic [7:0]  line_beats_m1 = '0, lines_m1 = '0, surfaces = '0;
  logic [31:0] src_line_pitch = '0, dst_line_pitch = '0;
  logic [31:0] src_surf_pitch = '0, dst_surf_pitch = '0;
  logic        beat_ready = 1'b0;
  logic        beat_valid, beat_last, done, busy, cfg_err;
  logic [31:0] beat_src_addr, beat_dst_addr;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cube_addr_gen u_cube_addr_gen (
    .clk (clk), .rst_n (rst_n), .start (start),
    .src_base (src_base), .dst_base (dst_base),
    .line_beats_m1 (line_beats_m1), .lines_m1 (lines_m1), .surfaces (surfaces),
    .src_line_pitch (src_line_pitch), .dst_line_pitch (dst_line_pitch),
    .src_surf_pitch (src_surf_pitch), .dst_surf_pitch (dst_surf_pitch),
    .beat_ready (beat_ready), .beat_valid (beat_valid),
    .beat_src_addr (beat_src_addr), .beat_dst_addr (beat_dst_addr),
    .beat_last (beat_last), .done (done), .busy (busy), .cfg_err (cfg_err)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Address of beat number idx, from the nested layout definition.
  function automatic logic [31:0] exp_addr(input logic [31:0] base, input int lb,
      input int nl, input logic [31:0] lp, input logic [31:0] sp, input int idx);
    int b = idx % lb;
    int l = (idx / lb) % nl;
    int s = idx / (lb * nl);
    return base + 32'(s) * sp + 32'(l) * lp + 32'(b * 32);
  endfunction

  task automatic run_desc(input logic [31:0] sb, input logic [31:0] db,
      input int lb, input int nl, input int ns,
      input logic [31:0] slp, input logic [31:0] dlp,
      input logic [31:0] ssp, input logic [31:0] dsp, input int ready_pct);
    int total = lb * nl * ns;
    int idx = 0;
    int guard = 0;
    bit fin = 0;
    @(negedge clk);
    src_base = sb; dst_base = db;
    line_beats_m1 = 8'(lb - 1); lines_m1 = 8'(nl - 1); surfaces = 8'(ns);
    src_line_pitch = slp; dst_line_pitch = dlp;
    src_surf_pitch = ssp; dst_surf_pitch = dsp;
    start = 1'b1; beat_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(beat_valid && busy, "R9 valid after start", {beat_valid, busy}, 2'b11);
    chk(beat_src_addr == sb && beat_dst_addr == db, "R9 first address",
        beat_src_addr, sb);
    while (!fin && guard < 20000) begin
      guard++;
      @(negedge clk);
      beat_ready = ($urandom % 100) < ready_pct;
      // R8: junk descriptor strobes while busy
      start = ($urandom % 4) == 0;
      src_base = $urandom; dst_base = $urandom;
      src_line_pitch = $urandom; surfaces = 8'($urandom);
      #1;
      chk(beat_valid, "R7 valid held until done", beat_valid, 1);
      chk(beat_src_addr == exp_addr(sb, lb, nl, slp, ssp, idx), "R2 R3 R4 R8 src address",
          beat_src_addr, exp_addr(sb, lb, nl, slp, ssp, idx));
      chk(beat_dst_addr == exp_addr(db, lb, nl, dlp, dsp, idx), "R2 R3 R4 R8 dst address",
          beat_dst_addr, exp_addr(db, lb, nl, dlp, dsp, idx));
      chk(beat_last == (idx == total - 1), "R5 last flag", beat_last, idx == total - 1);
      chk(done == (beat_ready && idx == total - 1), "R5 done pulse", done,
          beat_ready && idx == total - 1);
      if (beat_ready) begin
        idx++;
        if (idx == total) fin = 1;
      end
    end
    @(negedge clk);
    start = 1'b0; beat_ready = 1'b0;
    #1;
    chk(!beat_valid && !busy, "R5 idle after done", {beat_valid, busy}, 0);
    chk(idx == total, "R5 beat count", idx, total);
  endtask

  task automatic bad_desc(input logic [31:0] sb, input logic [31:0] lp, input int ns);
    @(negedge clk);
    src_base = sb; dst_base = 32'h100;
    line_beats_m1 = 8'd1; lines_m1 = 8'd1; surfaces = 8'(ns);
    src_line_pitch = lp; dst_line_pitch = 32'h40;
    src_surf_pitch = 32'h100; dst_surf_pitch = 32'h100;
    start = 1'b1; beat_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #1;
    chk(cfg_err, "R6 error raised", cfg_err, 1);
    chk(!beat_valid && !busy, "R6 no beats on error", {beat_valid, busy}, 0);
    @(negedge clk);
    #1;
    chk(!cfg_err && !beat_valid, "R6 error one cycle", {cfg_err, beat_valid}, 0);
    beat_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk(!beat_valid && !beat_last && !done && !cfg_err && !busy, "R1 reset state",
        {beat_valid, beat_last, done, cfg_err, busy}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!beat_valid && !busy, "R1 idle after reset", {beat_valid, busy}, 0);

    // Directed corners
    run_desc(32'h1000, 32'h8000, 1, 1, 1, 32'h20, 32'h20, 32'h20, 32'h20, 100);
    run_desc(32'h0, 32'h4000, 4, 1, 1, 32'h80, 32'h80, 32'h80, 32'h80, 100);
    run_desc(32'h200, 32'h600, 2, 3, 1, 32'h60, 32'h40, 32'h200, 32'h100, 60);
    run_desc(32'hFFFF_FF00, 32'h40, 2, 2, 3, 32'h80, 32'h40, 32'h200, 32'h80, 50);
    bad_desc(32'h1004, 32'h40, 2);
    bad_desc(32'h1000, 32'h41, 2);
    bad_desc(32'h1000, 32'h40, 0);

    // Constrained random descriptors
    for (int n = 0; n < 40; n++) begin
      int lb = 1 + ($urandom % 4);
      int nl = 1 + ($urandom % 4);
      int ns = 1 + ($urandom % 3);
      logic [31:0] slp = 32'((lb + ($urandom % 3)) * 32);
      logic [31:0] dlp = 32'((lb + ($urandom % 3)) * 32);
      logic [31:0] ssp = slp * 32'(nl) + 32'(($urandom % 4) * 32);
      logic [31:0] dsp = dlp * 32'(nl) + 32'(($urandom % 4) * 32);
      run_desc({$urandom} & 32'hFFFF_FFE0, {$urandom} & 32'hFFFF_FFE0,
               lb, nl, ns, slp, dlp, ssp, dsp, 30 + ($urandom % 71));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule